// File: doc/BRIEF.md
# Clock Source and Resume Sequencer

This block decides which oscillator clocks the core and when the CPU may run. The choice is between an on-chip oscillator and an off-chip resonator oscillator. The block also holds the CPU while a source is coming up. Software sets the desired source and the length of the post-stability hold through a small configuration register. A suspend request stops both oscillators. A wake event brings the core back on the source that the register names at that moment.

Hand-over to the external oscillator happens only in one direction while the core is running. Clearing the enable bit does not fall back to the internal oscillator. It only changes which source the next wake-up uses. The analog oscillators and the detector that reports a stable external clock are outside the block and appear as plain inputs. Every delay is counted in pulses of a 1 µs `tick` strobe.

A power or low-voltage reset forces the internal oscillator and holds the CPU for a start-up timeout. A watchdog reset only clears the configuration register.

Top module: `clk_resume_seq`

## Requirements
- R1: After `rstN` is released, `selExt`=0, `intOscEn`=1, `extOscEn`=0 and `cfgRdata`=0. `cpuRun` stays 0 until START_TICKS ticks have been counted and rises on the next clock.
- R2: The configuration register keeps bit 0 (external enable), bit 1 (clock-out disable) and bit 7 (long resume delay). The other bits are stored and read back as 0, so a write of 8'hFF reads back 8'h83.
- R3: `clkOutEn` is 1 only while the internal oscillator runs as the selected source and bit 1 is 0. In external mode it is 0 whatever bit 1 holds.
- R4: With the internal source running, a stored bit 0 of 1 takes effect by the second clock edge after the write: `cpuRun`=0, `intOscEn`=0, `extOscEn`=1, `selExt`=1. `cpuRun` then stays 0 for as long as `extStable` is 0.
- R5: After `extStable` is seen high, the CPU is held for SHORT_TICKS ticks if bit 7 is 0, or for LONG_TICKS ticks if bit 7 is 1. `cpuRun` rises on the clock after the last counted tick.
- R6: While running on the external source, register writes (including clearing bit 0) change neither `selExt`, `extOscEn` nor `cpuRun`.
- R7: A suspend request while running drops `cpuRun`, `intOscEn` and `extOscEn` on the next edge. A wake with bit 0 clear selects the internal source and releases the CPU after WAKE_TICKS ticks.
- R8: A wake with bit 0 set restarts the external oscillator (`selExt`=1, `extOscEn`=1). It then waits for `extStable` and applies the same delay as R5.
- R9: A watchdog reset pulse clears the whole configuration register but leaves the running source and `cpuRun` unchanged.
- R10: A `lvReset` pulse in any state clears the register and selects the internal oscillator with `cpuRun`=0. It then applies the R1 start-up timeout.
- R11: A suspend request that arrives while `wakeEvt` is already high still enters suspend for at least one cycle (`cpuRun`, `intOscEn` and `extOscEn` all 0). The wake sequence follows.
- R12: Each new delay sequence starts its count afresh from its full length. Clocks without a tick do not advance the count, and `cpuRun` is 0 for the whole delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| tick | input | 1 | 1 µs timebase strobe |
| lvReset | input | 1 | Low-voltage reset pulse |
| wdReset | input | 1 | Watchdog reset pulse |
| cfgWe | input | 1 | Configuration register write strobe |
| cfgWdata | input | 8 | Configuration write data |
| cfgRdata | output | 8 | Configuration read data |
| suspendReq | input | 1 | Request to enter suspend |
| wakeEvt | input | 1 | Wake condition, level |
| extStable | input | 1 | External oscillator reports stable |
| selExt | output | 1 | Core clock select, 1 = external |
| intOscEn | output | 1 | Internal oscillator enable |
| extOscEn | output | 1 | External oscillator enable |
| clkOutEn | output | 1 | Drive internal clock onto clock-out pin |
| cpuRun | output | 1 | CPU release |

## Verification
The hardest situation to reach from the ports is a wake-up onto the external source. That path needs the core already running on the external oscillator and bit 0 still set when suspend is entered. Since writing bit 0 in internal mode starts a switch at once, the stimulus first completes a full switch to external mode. It then writes the register from external mode, where the write has no effect, and only after that suspends and wakes. A second hard case is a low-voltage reset in the middle of a long post-stability delay. The bench lets about a thousand ticks of a 4000-tick hold pass before the reset, then requires the fresh start-up count in full. Randomised rounds mix register values with suspend and wake cycles and predict the source and release time from the bench's own model of the current mode.

// File: rtl/clk_resume_pkg.sv
package clk_resume_pkg;

  localparam int CFG_W        = 8;
  localparam int EXT_EN_BIT   = 0;
  localparam int OUT_DIS_BIT  = 1;
  localparam int LONG_DLY_BIT = 7;
  localparam logic [CFG_W-1:0] CFG_WR_MASK =
    CFG_W'((1 << EXT_EN_BIT) | (1 << OUT_DIS_BIT) | (1 << LONG_DLY_BIT));

  typedef enum logic [2:0] {
    ST_START,
    ST_RUN,
    ST_EXT_WAIT,
    ST_EXT_DLY,
    ST_SUSP,
    ST_INT_DLY
  } seq_state_e;

  typedef enum logic [1:0] {
    DLY_START,
    DLY_WAKE_INT,
    DLY_EXT_POST
  } dly_kind_e;

  typedef struct packed {
    logic      load;
    dly_kind_e kind;
  } dp_strobe_t;

  function automatic int maxTicks(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/clk_resume_dp.sv
module clk_resume_dp
  import clk_resume_pkg::*;
#(
  parameter int SHORT_TICKS = 128,
  parameter int LONG_TICKS  = 4000,
  parameter int WAKE_TICKS  = 8,
  parameter int START_TICKS = 64,
  localparam int CW = $clog2(maxTicks(SHORT_TICKS, LONG_TICKS, WAKE_TICKS, START_TICKS) + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             lvReset,
  input  logic             wdReset,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  input  dp_strobe_t       strobe,
  input  logic             intOscEn,
  input  logic             selExt,
  output logic [CFG_W-1:0] cfgRdata,
  output logic             cfgExtEn,
  output logic             cntZero,
  output logic             clkOutEn
);

  logic [CFG_W-1:0] cfgReg;
  logic [CW-1:0]    cnt;
  logic [CW-1:0]    loadVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else if (lvReset || wdReset) begin
      cfgReg <= '0;
    end else if (cfgWe) begin
      cfgReg <= cfgWdata & CFG_WR_MASK;
    end
  end

  always_comb begin
    case (strobe.kind)
      DLY_WAKE_INT: loadVal = CW'(WAKE_TICKS);
      DLY_EXT_POST: loadVal = cfgReg[LONG_DLY_BIT] ? CW'(LONG_TICKS) : CW'(SHORT_TICKS);
      default:      loadVal = CW'(START_TICKS);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= CW'(START_TICKS);
    end else if (strobe.load) begin
      cnt <= loadVal;
    end else if (tick && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cfgRdata = cfgReg;
  assign cfgExtEn = cfgReg[EXT_EN_BIT];
  assign cntZero  = (cnt == '0);
  assign clkOutEn = intOscEn && !selExt && !cfgReg[OUT_DIS_BIT];

  AST_WD_CLEARS_CFG: assert property (@(posedge clk) disable iff (!rstN)
    (wdReset || lvReset) |=> (cfgRdata == '0)); // R9

  AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !cntZero); // R12

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !strobe.load && !cntZero) |=> !cntZero); // R12

endmodule

// File: rtl/clk_resume_ctrl.sv
module clk_resume_ctrl
  import clk_resume_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lvReset,
  input  logic       suspendReq,
  input  logic       wakeEvt,
  input  logic       extStable,
  input  logic       cfgExtEn,
  input  logic       cntZero,
  output dp_strobe_t strobe,
  output logic       selExt,
  output logic       intOscEn,
  output logic       extOscEn,
  output logic       cpuRun
);

  seq_state_e state, nextState;
  logic       activeExt, nextExt;

  function automatic logic isDelay(seq_state_e s);
    return (s == ST_START) || (s == ST_EXT_DLY) || (s == ST_INT_DLY);
  endfunction

  always_comb begin
    nextState = state;
    if (lvReset) begin
      nextState = ST_START;
    end else begin
      case (state)
        ST_START:    if (cntZero) nextState = ST_RUN;
        ST_RUN: begin
          if (suspendReq)                 nextState = ST_SUSP;
          else if (!activeExt && cfgExtEn) nextState = ST_EXT_WAIT;
        end
        ST_EXT_WAIT: if (extStable) nextState = ST_EXT_DLY;
        ST_EXT_DLY:  if (cntZero)   nextState = ST_RUN;
        ST_SUSP:     if (wakeEvt)   nextState = cfgExtEn ? ST_EXT_WAIT : ST_INT_DLY;
        ST_INT_DLY:  if (cntZero)   nextState = ST_RUN;
        default:     nextState = ST_START;
      endcase
    end
  end

  always_comb begin
    if (nextState == ST_EXT_WAIT) begin
      nextExt = 1'b1;
    end else if ((nextState == ST_START) || (nextState == ST_INT_DLY)) begin
      nextExt = 1'b0;
    end else begin
      nextExt = activeExt;
    end
  end

  always_comb begin
    strobe.load = isDelay(nextState) && ((nextState != state) || lvReset);
    case (nextState)
      ST_INT_DLY: strobe.kind = DLY_WAKE_INT;
      ST_EXT_DLY: strobe.kind = DLY_EXT_POST;
      default:    strobe.kind = DLY_START;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_START;
      activeExt <= 1'b0;
    end else begin
      state     <= nextState;
      activeExt <= nextExt;
    end
  end

  assign selExt   = activeExt;
  assign cpuRun   = (state == ST_RUN);
  assign intOscEn = (state == ST_START) || (state == ST_INT_DLY) ||
                    ((state == ST_RUN) && !activeExt);
  assign extOscEn = (state == ST_EXT_WAIT) || (state == ST_EXT_DLY) ||
                    ((state == ST_RUN) && activeExt);

  AST_RUN_AFTER_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    cpuRun |-> cntZero); // R12

  AST_OSC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(intOscEn && extOscEn)); // R4

  AST_EXT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRun && selExt && !suspendReq && !lvReset) |=> (cpuRun && selExt)); // R6

  AST_LV_FORCES_INT: assert property (@(posedge clk) disable iff (!rstN)
    lvReset |=> (!selExt && intOscEn && !cpuRun)); // R10

  AST_HOLD_UNTIL_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_EXT_WAIT) && !extStable && !lvReset) |=> !cpuRun); // R4

  AST_SUSPEND_ENTERED: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRun && suspendReq && !lvReset) |=> (!cpuRun && !intOscEn && !extOscEn)); // R11

endmodule

// File: rtl/clk_resume_seq.sv
module clk_resume_seq
  import clk_resume_pkg::*;
#(
  parameter int SHORT_TICKS = 128,
  parameter int LONG_TICKS  = 4000,
  parameter int WAKE_TICKS  = 8,
  parameter int START_TICKS = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             lvReset,
  input  logic             wdReset,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  output logic [CFG_W-1:0] cfgRdata,
  input  logic             suspendReq,
  input  logic             wakeEvt,
  input  logic             extStable,
  output logic             selExt,
  output logic             intOscEn,
  output logic             extOscEn,
  output logic             clkOutEn,
  output logic             cpuRun
);

  dp_strobe_t strobe;
  logic       cfgExtEn;
  logic       cntZero;

  clk_resume_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .lvReset    (lvReset),
    .suspendReq (suspendReq),
    .wakeEvt    (wakeEvt),
    .extStable  (extStable),
    .cfgExtEn   (cfgExtEn),
    .cntZero    (cntZero),
    .strobe     (strobe),
    .selExt     (selExt),
    .intOscEn   (intOscEn),
    .extOscEn   (extOscEn),
    .cpuRun     (cpuRun)
  );

  clk_resume_dp #(
    .SHORT_TICKS (SHORT_TICKS),
    .LONG_TICKS  (LONG_TICKS),
    .WAKE_TICKS  (WAKE_TICKS),
    .START_TICKS (START_TICKS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .lvReset  (lvReset),
    .wdReset  (wdReset),
    .cfgWe    (cfgWe),
    .cfgWdata (cfgWdata),
    .strobe   (strobe),
    .intOscEn (intOscEn),
    .selExt   (selExt),
    .cfgRdata (cfgRdata),
    .cfgExtEn (cfgExtEn),
    .cntZero  (cntZero),
    .clkOutEn (clkOutEn)
  );

endmodule

// File: tb/clk_resume_seq_tb.sv
module clk_resume_seq_tb;

  localparam int CLK_PERIOD  = 10;
  localparam int SHORT_TICKS = 128;
  localparam int LONG_TICKS  = 4000;
  localparam int WAKE_TICKS  = 8;
  localparam int START_TICKS = 64;

  logic       clk = 1'b0;
  logic       rstN, tick, lvReset, wdReset, cfgWe;
  logic [7:0] cfgWdata, cfgRdata;
  logic       suspendReq, wakeEvt, extStable;
  logic       selExt, intOscEn, extOscEn, clkOutEn, cpuRun;

  int checks = 0;
  int fails  = 0;
  bit expExt = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_resume_seq #(
    .SHORT_TICKS (SHORT_TICKS),
    .LONG_TICKS  (LONG_TICKS),
    .WAKE_TICKS  (WAKE_TICKS),
    .START_TICKS (START_TICKS)
  ) u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .lvReset(lvReset), .wdReset(wdReset),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .suspendReq(suspendReq), .wakeEvt(wakeEvt), .extStable(extStable),
    .selExt(selExt), .intOscEn(intOscEn), .extOscEn(extOscEn),
    .clkOutEn(clkOutEn), .cpuRun(cpuRun)
  );

  function automatic int postDelay(bit longDly);
    return longDly ? LONG_TICKS : SHORT_TICKS;
  endfunction

  function automatic int readBack(logic [7:0] v);
    return int'(v & 8'h83);
  endfunction

  task automatic chkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // counts posedges from the next one until cpuRun is seen high
  task automatic measureRun(output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      #1;
    end while (!cpuRun && n < 20000);
  endtask

  task automatic writeCfg(input logic [7:0] v);
    @(negedge clk);
    cfgWe = 1'b1;
    cfgWdata = v;
    @(negedge clk);
    cfgWe = 1'b0;
    cfgWdata = 8'h00;
  endtask

  // called right after a write of bit 0 while the internal source runs
  task automatic switchAfterWrite(input bit longDly);
    int n;
    @(negedge clk);
    chkEq("R4 cpuRun low on switch", cpuRun, 0);
    chkEq("R4 internal osc off", intOscEn, 0);
    chkEq("R4 external osc on", extOscEn, 1);
    chkEq("R4 select external", selExt, 1);
    repeat (12) @(negedge clk);
    chkEq("R4 held without stable", cpuRun, 0);
    extStable = 1'b1;
    measureRun(n);
    chkEq("R5 post-stable delay", n, postDelay(longDly) + 2);
    chkEq("R3 no clock out in external", clkOutEn, 0);
    expExt = 1'b1;
  endtask

  task automatic suspendNow();
    @(negedge clk);
    suspendReq = 1'b1;
    @(negedge clk);
    suspendReq = 1'b0;
    extStable = 1'b0;
    chkEq("R7 cpuRun low in suspend", cpuRun, 0);
    chkEq("R7 internal osc off in suspend", intOscEn, 0);
    chkEq("R7 external osc off in suspend", extOscEn, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic wakeInternal();
    int n;
    wakeEvt = 1'b1;
    measureRun(n);
    @(negedge clk);
    wakeEvt = 1'b0;
    chkEq("R7 internal wake delay", n, WAKE_TICKS + 2);
    chkEq("R7 internal selected after wake", selExt, 0);
    chkEq("R7 internal osc on after wake", intOscEn, 1);
    expExt = 1'b0;
  endtask

  task automatic wakeExternal(input bit longDly);
    int n;
    wakeEvt = 1'b1;
    @(negedge clk);
    wakeEvt = 1'b0;
    chkEq("R8 external select on wake", selExt, 1);
    chkEq("R8 external osc restarted", extOscEn, 1);
    chkEq("R8 cpuRun low before stable", cpuRun, 0);
    repeat (10) @(negedge clk);
    chkEq("R8 held without stable", cpuRun, 0);
    extStable = 1'b1;
    measureRun(n);
    chkEq("R8 external wake delay", n, postDelay(longDly) + 2);
    expExt = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int unsigned r;
    bit e, lg, od;
    rstN = 1'b0; tick = 1'b1; lvReset = 1'b0; wdReset = 1'b0;
    cfgWe = 1'b0; cfgWdata = 8'h00; suspendReq = 1'b0; wakeEvt = 1'b0; extStable = 1'b0;
    void'($urandom(32'd20240611));

    // R1 reset state and start-up timeout
    repeat (3) @(negedge clk);
    chkEq("R1 cpuRun in reset", cpuRun, 0);
    chkEq("R1 internal select", selExt, 0);
    chkEq("R1 internal osc on", intOscEn, 1);
    chkEq("R1 external osc off", extOscEn, 0);
    chkEq("R1 cfg cleared", cfgRdata, 0);
    rstN = 1'b1;
    measureRun(n);
    chkEq("R1 start-up timeout", n, START_TICKS + 1);
    chkEq("R3 clock out enabled", clkOutEn, 1);

    // R2 masked readback without bit 0, R3 output disable
    writeCfg(8'h7E);
    chkEq("R2 readback masked", cfgRdata, 8'h02);
    chkEq("R3 clock out disabled", clkOutEn, 0);
    repeat (3) @(negedge clk);
    chkEq("R2 no switch without bit 0", selExt, 0);
    chkEq("R2 still running", cpuRun, 1);
    writeCfg(8'h00);
    chkEq("R3 clock out back on", clkOutEn, 1);

    // R4/R5 switch with short delay
    writeCfg(8'h01);
    switchAfterWrite(1'b0);

    // R6 clearing bit 0 while external is ignored
    writeCfg(8'h00);
    repeat (5) @(negedge clk);
    chkEq("R6 external kept", selExt, 1);
    chkEq("R6 external osc kept", extOscEn, 1);
    chkEq("R6 cpu still runs", cpuRun, 1);
    chkEq("R6 readback cleared", cfgRdata, 0);

    // R2 full write from external mode
    writeCfg(8'hFF);
    chkEq("R2 readback of all ones", cfgRdata, 8'h83);
    chkEq("R6 external kept after write", selExt, 1);
    chkEq("R3 no clock out in external", clkOutEn, 0);

    // R8 wake on external with long delay
    suspendNow();
    wakeExternal(1'b1);

    // R9 watchdog clears register only
    @(negedge clk);
    wdReset = 1'b1;
    @(negedge clk);
    wdReset = 1'b0;
    chkEq("R9 cfg cleared by watchdog", cfgRdata, 0);
    chkEq("R9 source unchanged", selExt, 1);
    chkEq("R9 cpu still runs", cpuRun, 1);
    repeat (3) @(negedge clk);
    chkEq("R9 source still unchanged", selExt, 1);

    // R7 wake onto internal after watchdog cleared bit 0
    suspendNow();
    wakeInternal();

    // R12 delay counts ticks only
    suspendNow();
    tick = 1'b0;
    wakeEvt = 1'b1;
    @(negedge clk);
    wakeEvt = 1'b0;
    repeat (30) @(negedge clk);
    chkEq("R12 no release without ticks", cpuRun, 0);
    tick = 1'b1;
    measureRun(n);
    chkEq("R12 release after ticks resume", n, WAKE_TICKS + 1);

    // R11 wake already present when suspend requested
    @(negedge clk);
    suspendReq = 1'b1;
    wakeEvt = 1'b1;
    @(negedge clk);
    suspendReq = 1'b0;
    chkEq("R11 suspend entered cpuRun", cpuRun, 0);
    chkEq("R11 suspend entered osc", intOscEn | extOscEn, 0);
    measureRun(n);
    @(negedge clk);
    wakeEvt = 1'b0;
    chkEq("R11 wake follows suspend", n, WAKE_TICKS + 2);

    // R10 low-voltage reset in the middle of a long delay
    writeCfg(8'h81);
    @(negedge clk);
    extStable = 1'b1;
    repeat (1000) @(negedge clk);
    chkEq("R12 held during long delay", cpuRun, 0);
    lvReset = 1'b1;
    @(negedge clk);
    lvReset = 1'b0;
    extStable = 1'b0;
    chkEq("R10 internal selected", selExt, 0);
    chkEq("R10 internal osc on", intOscEn, 1);
    chkEq("R10 external osc off", extOscEn, 0);
    chkEq("R10 cpu held", cpuRun, 0);
    chkEq("R10 cfg cleared", cfgRdata, 0);
    measureRun(n);
    chkEq("R10 fresh start-up timeout", n, START_TICKS + 1);
    expExt = 1'b0;

    // randomised rounds
    for (int i = 0; i < 12; i++) begin
      r  = $urandom;
      e  = r[0];
      lg = (r[3:1] == 3'd0);
      od = r[4];
      writeCfg({lg, 5'b00000, od, e});
      chkEq("R2 random readback", cfgRdata, readBack({lg, 5'b11111, od, e}));
      if (!expExt && e) begin
        switchAfterWrite(lg);
      end else begin
        @(negedge clk);
        chkEq("R6 random mode kept", selExt, expExt);
        chkEq("R6 random still running", cpuRun, 1);
      end
      chkEq("R3 random clock out", clkOutEn, (!expExt && !od) ? 1 : 0);
      suspendNow();
      if (e) wakeExternal(lg);
      else   wakeInternal();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule